// File: doc/BRIEF.md
# Register-Mapped SPI Master with Word FIFOs

This block is an SPI bus master controlled through a small register window. Software fills a transmit FIFO with words, picks one of four chip-select lanes, a word length and a clock divider in the control register, and sets an exchange bit. The controller then pulls words from the transmit FIFO and shifts each one out on the serial data output while it shifts a word in from the serial data input. Every received word goes into a receive FIFO, which software drains through the receive data register.

Each lane has its own clock phase, clock polarity, idle clock level and chip-select polarity in a shared configuration register. The serial clock rate comes from a divider with a linear pre-scaler and a power-of-two post-scaler. One interrupt line reports the enabled conditions: transmit FIFO empty and receive data ready.

Top module: `spim_top`

## Requirements
- R1: Register offsets are receive data 0x00, transmit data 0x04, control 0x08, lane configuration 0x0C, interrupt enable 0x10 and status 0x18. Control, configuration and interrupt enable read back what was written (interrupt enable keeps only bits 0 and 3). Control bit 0 enables the block and bit 2 is the exchange bit.
- R2: With the exchange bit set and the block enabled, the controller shifts every queued transmit word out most significant bit first and pushes exactly one received word per transmitted word into the receive FIFO. With MISO tied to MOSI the received words equal the sent ones in all four phase and polarity settings.
- R3: Control bits 24:20 hold the word length minus one (1 to 32 bits). Only the low length bits of a transmit word are sent; received words have all higher bits at zero.
- R4: Both FIFOs hold 64 words. A transmit-data write while the transmit FIFO is full is dropped, and a receive-data read while the receive FIFO is empty returns zero.
- R5: Status bit 3 is 1 exactly while the receive FIFO holds a word, and each receive-data read pops one word in order.
- R6: The exchange bit clears itself once the transmit FIFO is empty and the last word has finished. Set with an empty transmit FIFO it clears without any serial clock edge; set while the block is disabled it stays pending and nothing is shifted until the block is enabled.
- R7: Control bits 19:18 select the lane. Configuration bit lane+12 gives the active level of that chip-select (1 = active high); the selected chip-select is asserted once for the whole exchange, held between words, and released after the last word. Unselected lanes stay inactive.
- R8: Outside an exchange SCLK sits at configuration bit lane+20. Configuration bit lane+4 is the clock polarity and bit lane the clock phase of the selected lane.
- R9: Each SCLK half-period lasts (pre+1)·2^post clock cycles, with pre in control bits 15:12 and post in control bits 11:8.
- R10: The interrupt output is high when enable bit 0 is set and the transmit FIFO is empty, or enable bit 3 is set and the receive FIFO is not empty; otherwise low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip-select lanes |

## Verification
The assertions watch, on every cycle, that at most one chip-select lane is active and none outside an exchange, that SCLK rests at the idle level whenever the engine is idle, that the exchange bit is gone when the engine stops, that the interrupt follows its enables, and that neither FIFO level passes its depth. Data integrity across the four clock modes, the word-length masking, the dropped write into a full FIFO, the zero read from an empty one, the pending exchange while disabled and the divider half-period can only be shown by the bench scenarios, which compare read-back words and measured SCLK spacing with values worked out from the requirements.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_RXD  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_TXD  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CFG  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_IEN  = 5'h10;
  localparam logic [REG_AW-1:0] OFS_STAT = 5'h18;

  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_XCH_BIT = 2;
  localparam int unsigned IEN_TXE_BIT = 0;
  localparam int unsigned IEN_RXR_BIT = 3;
  localparam int unsigned STAT_RR_BIT = 3;

  // SCLK half period in system clock cycles
  function automatic logic [19:0] spim_half_cycles(input logic [3:0] pre, input logic [3:0] post);
    logic [19:0] base;
    base = {16'd0, pre} + 20'd1;
    return base << post;
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign level   = cnt;
  assign head    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] pre,
  input  logic [3:0] post,
  output logic       tick
);
  logic [19:0] cnt;
  logic [19:0] half;

  assign half = spim_half_cycles(pre, post);
  assign tick = run && (cnt == half - 20'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 20'd1;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DW = 32,
  parameter int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          tick,
  input  logic          cpha,
  input  logic          cpol,
  input  logic          miso,
  input  logic          tx_empty,
  input  logic [BW-1:0] last_bit,
  input  logic [DW-1:0] tx_word,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          xfer_done,
  output logic          busy,
  output logic          sclk_int,
  output logic          mosi
);
  logic          busy_q, sclk_q, lead_q, first_q;
  logic [BW-1:0] cnt_q;
  logic [DW-1:0] tx_sh, rx_sh;

  // named events for the checker and for readability
  logic start_evt, empty_evt, lead_evt, trail_evt, word_end;

  assign start_evt = !busy_q && go && !tx_empty;
  assign empty_evt = !busy_q && go && tx_empty;
  assign lead_evt  = busy_q && tick && lead_q;
  assign trail_evt = busy_q && tick && !lead_q;
  assign word_end  = trail_evt && (cnt_q == '0);

  assign tx_pop    = start_evt || (word_end && !tx_empty);
  assign rx_push   = word_end;
  assign rx_word   = cpha ? {rx_sh[DW-2:0], miso} : rx_sh;
  assign xfer_done = empty_evt || (word_end && tx_empty);
  assign busy      = busy_q;
  assign sclk_int  = sclk_q;
  assign mosi      = busy_q & tx_sh[last_bit];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b1;
      first_q <= 1'b1;
      cnt_q   <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else if (start_evt) begin
      busy_q  <= 1'b1;
      sclk_q  <= cpol;
      lead_q  <= 1'b1;
      first_q <= 1'b1;
      cnt_q   <= last_bit;
      tx_sh   <= tx_word;
      rx_sh   <= '0;
    end else if (lead_evt) begin
      sclk_q  <= ~sclk_q;
      lead_q  <= 1'b0;
      first_q <= 1'b0;
      if (!cpha)         rx_sh <= {rx_sh[DW-2:0], miso};
      else if (!first_q) tx_sh <= tx_sh << 1;
    end else if (trail_evt) begin
      sclk_q <= ~sclk_q;
      lead_q <= 1'b1;
      if (word_end) begin
        if (tx_empty) begin
          busy_q <= 1'b0;
        end else begin
          tx_sh   <= tx_word;
          rx_sh   <= '0;
          cnt_q   <= last_bit;
          first_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (cpha) rx_sh <= {rx_sh[DW-2:0], miso};
        else      tx_sh <= tx_sh << 1;
      end
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LANES      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [LANES-1:0]  cs
);
  localparam int DW = REG_DW;
  localparam int BW = $clog2(DW);
  localparam int LW = $clog2(FIFO_DEPTH) + 1;
  localparam int SW = $clog2(LANES);

  logic [REG_DW-1:0] ctrl_q, cfg_q;
  logic              xch_q, ien_txe, ien_rxr;

  // control fields
  logic          blk_en;
  logic [3:0]    div_pre, div_post;
  logic [SW-1:0] lane;
  logic [BW-1:0] last_bit;
  assign blk_en   = ctrl_q[CTL_EN_BIT];
  assign div_post = ctrl_q[11:8];
  assign div_pre  = ctrl_q[15:12];
  assign lane     = ctrl_q[18 +: SW];
  assign last_bit = ctrl_q[20 +: BW];

  // per-lane configuration
  logic [LANES-1:0] pha_v, pol_v, cs_act_lvl, idle_v;
  assign pha_v      = cfg_q[0  +: LANES];
  assign pol_v      = cfg_q[4  +: LANES];
  assign cs_act_lvl = cfg_q[12 +: LANES];
  assign idle_v     = cfg_q[20 +: LANES];
  logic idle_lvl;
  assign idle_lvl = idle_v[lane];

  // bus decode
  logic wr_ctrl, wr_cfg, wr_ien, wr_txd, rd_rxd;
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_cfg  = bus_wr && (bus_addr == OFS_CFG);
  assign wr_ien  = bus_wr && (bus_addr == OFS_IEN);
  assign wr_txd  = bus_wr && (bus_addr == OFS_TXD);
  assign rd_rxd  = bus_rd && (bus_addr == OFS_RXD);

  // FIFOs
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_pop, rx_push;

  spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_txd), .wdata(bus_wdata), .pop(tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level));

  spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word), .pop(rd_rxd),
    .head(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level));

  // engine and divider
  logic busy, tick, xfer_done, sclk_int;

  spim_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .pre(div_pre), .post(div_post), .tick(tick));

  spim_shifter #(.DW(DW), .BW(BW)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(xch_q && blk_en), .tick(tick),
    .cpha(pha_v[lane]), .cpol(pol_v[lane]), .miso(miso), .tx_empty(tx_empty),
    .last_bit(last_bit), .tx_word(tx_head), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_word(rx_word), .xfer_done(xfer_done), .busy(busy), .sclk_int(sclk_int),
    .mosi(mosi));

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cfg_q   <= '0;
      xch_q   <= 1'b0;
      ien_txe <= 1'b0;
      ien_rxr <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & ~(REG_DW'(1) << CTL_XCH_BIT);
      if (wr_cfg)  cfg_q  <= bus_wdata;
      if (wr_ien) begin
        ien_txe <= bus_wdata[IEN_TXE_BIT];
        ien_rxr <= bus_wdata[IEN_RXR_BIT];
      end
      if (wr_ctrl && bus_wdata[CTL_XCH_BIT]) xch_q <= 1'b1;
      else if (xfer_done)                    xch_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
      OFS_CTRL: begin
        bus_rdata = ctrl_q;
        bus_rdata[CTL_XCH_BIT] = xch_q;
      end
      OFS_CFG:  bus_rdata = cfg_q;
      OFS_IEN: begin
        bus_rdata[IEN_TXE_BIT] = ien_txe;
        bus_rdata[IEN_RXR_BIT] = ien_rxr;
      end
      OFS_STAT: bus_rdata[STAT_RR_BIT] = !rx_empty;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq  = (ien_txe && tx_empty) || (ien_rxr && !rx_empty);
  assign sclk = busy ? sclk_int : idle_lvl;

  for (genvar n = 0; n < LANES; n++) begin : g_cs
    assign cs[n] = (busy && lane == SW'(n)) ? cs_act_lvl[n] : ~cs_act_lvl[n];
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int LW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] cs_line,
  input logic [LANES-1:0] cs_act_lvl,
  input logic             busy,
  input logic             xch,
  input logic             sclk,
  input logic             idle_lvl,
  input logic             irq,
  input logic             ien_txe,
  input logic             ien_rxr,
  input logic [LW-1:0]    rx_level,
  input logic [LW-1:0]    tx_level
);
  logic [LANES-1:0] active_lanes;
  assign active_lanes = cs_line ^ ~cs_act_lvl;

  p_cs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active_lanes));
  p_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (active_lanes == '0));
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == idle_lvl));
  p_xch_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !xch);
  p_busy_has_xch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> xch);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_txe && !ien_rxr) |-> !irq);
  p_irq_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_rxr && rx_level != '0) |-> irq);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));
endmodule

bind spim_top spim_checker #(.DEPTH(FIFO_DEPTH), .LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_line(cs), .cs_act_lvl(cs_act_lvl), .busy(busy),
  .xch(xch_q), .sclk(sclk), .idle_lvl(idle_lvl), .irq(irq), .ien_txe(ien_txe),
  .ien_rxr(ien_rxr), .rx_level(rx_level), .tx_level(tx_level));

// File: tb/test_spim_top.sv
`timescale 1ns/1ps
module test_spim_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  cs;
  logic        loop_en = 1'b1;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign miso = loop_en ? mosi : 1'b1;

  spim_top i_spim_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs(cs));

  // monitor: SCLK toggles, spacing, chip-select assertions
  logic [3:0] pol_copy = 4'h0;
  int  sclk_toggles = 0, cyc = 0, last_tog = -1, first_gap = -1, cs_asserts = 0, cs_lane = -1;
  logic prev_sclk = 1'b0;
  logic [3:0] prev_act = 4'h0;
  always @(negedge clk) begin
    logic [3:0] act;
    cyc++;
    act = cs ^ ~pol_copy;
    if (rst_n && sclk !== prev_sclk) begin
      sclk_toggles++;
      if (last_tog >= 0 && first_gap < 0) first_gap = cyc - last_tog;
      last_tog = cyc;
    end
    if (rst_n && act != 4'h0 && prev_act == 4'h0) begin
      cs_asserts++;
      for (int k = 0; k < 4; k++) if (act[k]) cs_lane = k;
    end
    prev_sclk = sclk;
    prev_act  = act;
  end

  task automatic clr_mon();
    sclk_toggles = 0; last_tog = -1; first_gap = -1; cs_asserts = 0; cs_lane = -1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_xch(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h08, v);
      if (!v[2]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] wmask(input int bl);
    return (bl == 31) ? 32'hFFFF_FFFF : ((32'd1 << (bl + 1)) - 32'd1);
  endfunction

  function automatic logic [31:0] ctrl_word(input int lane, input int bl, input int pre, input int post);
    return 32'h1 | 32'hF0 | (32'(post) << 8) | (32'(pre) << 12) | (32'(lane) << 18) | (32'(bl) << 20);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check(cs == 4'hF, "R7", "reset cs inactive", {28'd0, cs}, 32'hF);
    check(sclk == 1'b0, "R8", "reset sclk idle", {31'd0, sclk}, 0);
    check(irq == 1'b0, "R10", "reset irq", {31'd0, irq}, 0);
    rd(5'h08, v); check(v == 0, "R1", "reset ctrl", v, 0);
    rd(5'h18, v); check(v == 0, "R5", "reset status", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h0C, 32'h00A5_5A3C); rd(5'h0C, v);
    check(v == 32'h00A5_5A3C, "R1", "cfg readback", v, 32'h00A5_5A3C);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v);
    check(v == 32'h9, "R1", "ien readback", v, 32'h9);
    wr(5'h10, 0);
    wr(5'h08, 32'h0123_4560); rd(5'h08, v);
    check(v == 32'h0123_4560, "R1", "ctrl readback", v, 32'h0123_4560);
    wr(5'h08, 0); wr(5'h0C, 0);
  endtask

  // one exchange of n words on a lane with given phase/polarity/cs polarity
  task automatic t_loop(input int lane, input bit pha, input bit pol, input bit cshi,
                        input int bl, input int n, input logic [31:0] seed);
    logic [31:0] v, cfg, exp;
    bit ok;
    cfg = (32'(pha) << lane) | (32'(pol) << (lane + 4)) | (32'(cshi) << (lane + 12)) | (32'(pol) << (lane + 20));
    pol_copy = cfg[15:12];
    wr(5'h0C, cfg);
    wr(5'h08, ctrl_word(lane, bl, 0, 0));
    check(sclk == pol, "R8", "idle sclk level", {31'd0, sclk}, {31'd0, pol});
    for (int i = 0; i < n; i++) wr(5'h04, seed * 32'(i + 3) + 32'h1357_9BDF);
    clr_mon();
    wr(5'h08, ctrl_word(lane, bl, 0, 0) | 32'h4);
    wait_xch(ok);
    check(ok, "R6", "xch self-clear", {31'd0, ok}, 1);
    check(cs_asserts == 1, "R7", "one cs assertion per exchange", 32'(cs_asserts), 1);
    check(cs_lane == lane, "R7", "asserted lane", 32'(cs_lane), 32'(lane));
    check((cs ^ ~pol_copy) == 4'h0, "R7", "cs released", {28'd0, cs}, {28'd0, ~pol_copy});
    check(sclk == pol, "R8", "sclk back to idle", {31'd0, sclk}, {31'd0, pol});
    check(sclk_toggles == 2 * n * (bl + 1), "R2", "sclk edge count", 32'(sclk_toggles), 32'(2 * n * (bl + 1)));
    for (int i = 0; i < n; i++) begin
      exp = (seed * 32'(i + 3) + 32'h1357_9BDF) & wmask(bl);
      rd(5'h00, v);
      check(v == exp, "R2", "loopback word", v, exp);
    end
    rd(5'h18, v); check(v[3] == 1'b0, "R5", "RR clear after drain", v, 0);
  endtask

  task automatic t_width();
    logic [31:0] v;
    bit ok;
    loop_en = 1'b0;
    pol_copy = 4'h0; wr(5'h0C, 0);
    wr(5'h04, 32'h0);
    wr(5'h08, ctrl_word(1, 4, 0, 0) | 32'h4);
    wait_xch(ok);
    rd(5'h18, v); check(v[3] == 1'b1, "R5", "RR set with data", v, 32'h8);
    rd(5'h00, v); check(v == 32'h1F, "R3", "5-bit word of ones", v, 32'h1F);
    loop_en = 1'b1;
    t_loop(3, 1'b0, 1'b0, 1'b0, 31, 2, 32'hDEAD_BEEF);
  endtask

  task automatic t_full();
    logic [31:0] v;
    bit ok;
    pol_copy = 4'h0; wr(5'h0C, 0);
    wr(5'h08, 32'h0070_0000);  // disabled, 8-bit words
    for (int i = 0; i < 65; i++) wr(5'h04, 32'(i + 1));
    clr_mon();
    wr(5'h08, 32'h0070_0004);
    repeat (40) @(posedge clk);
    rd(5'h08, v); check(v[2] == 1'b1, "R6", "xch pending while disabled", v, 32'h0070_0004);
    check(sclk_toggles == 0, "R6", "no sclk while disabled", 32'(sclk_toggles), 0);
    wr(5'h08, 32'h0070_0001);
    wait_xch(ok);
    check(ok && sclk_toggles == 64 * 16, "R4", "only 64 words shifted", 32'(sclk_toggles), 32'(64 * 16));
    for (int i = 0; i < 64; i++) begin
      rd(5'h00, v);
      if (i == 0 || i == 63) check(v == 32'(i + 1), "R5", "rx order", v, 32'(i + 1));
    end
    rd(5'h00, v); check(v == 0, "R4", "empty rx read is zero", v, 0);
  endtask

  task automatic t_empty_xch();
    logic [31:0] v;
    clr_mon();
    wr(5'h08, 32'h0070_0005);
    @(posedge clk);
    rd(5'h08, v); check(v[2] == 1'b0, "R6", "xch clears on empty fifo", v, 32'h0070_0001);
    check(sclk_toggles == 0 && cs_asserts == 0, "R6", "no activity on empty xch", 32'(sclk_toggles), 0);
  endtask

  task automatic t_div();
    logic [31:0] v;
    bit ok;
    wr(5'h04, 32'h2);
    clr_mon();
    wr(5'h08, ctrl_word(0, 1, 2, 1) | 32'h4);
    wait_xch(ok);
    check(first_gap == 6, "R9", "half period pre=2 post=1", 32'(first_gap), 6);
    rd(5'h00, v); check(v == 32'h2, "R2", "2-bit word", v, 2);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    bit ok;
    wr(5'h10, 32'h1); #1;
    check(irq == 1'b1, "R10", "irq on tx empty", {31'd0, irq}, 1);
    wr(5'h10, 32'h8); #1;
    check(irq == 1'b0, "R10", "no irq, rx empty", {31'd0, irq}, 0);
    wr(5'h04, 32'h5A);
    wr(5'h08, ctrl_word(0, 7, 0, 0) | 32'h4);
    wait_xch(ok); #1;
    check(irq == 1'b1, "R10", "irq on rx ready", {31'd0, irq}, 1);
    rd(5'h00, v); #1;
    check(irq == 1'b0 && v == 32'h5A, "R10", "irq drops after pop", v, 32'h5A);
    wr(5'h10, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_regs();
    t_loop(0, 1'b0, 1'b0, 1'b0, 7, 3, 32'h0000_00A7);
    t_loop(1, 1'b1, 1'b0, 1'b1, 15, 2, 32'h0001_2345);
    t_loop(2, 1'b1, 1'b1, 1'b1, 11, 3, 32'h00C0_FFEE);
    t_loop(3, 1'b0, 1'b1, 1'b0, 0, 4, 32'h0000_0005);
    t_width();
    t_full();
    t_empty_xch();
    t_div();
    t_irq();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule